// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words. Its write side and read side each have their own clock. The two clocks may be fully unrelated, or both pins may be driven from one clock. A word enters on a write-clock edge only when both write enables are high. A word leaves on a read-clock edge only when both read enables are high. The write side reports Full and Almost-Full. The read side reports Empty and Almost-Empty. Each side works these flags out from its own pointer and a synchronized Gray-coded copy of the other side's pointer.

The two threshold offsets live in a four-entry offset store. Each entry is 8 bits. While the configuration-load input is high, the data ports talk to this store instead of the queue:

- Each qualified write stores `wr_data[7:0]` into the next entry.
- Each qualified read returns the next entry on `rd_data` as `{1'b0, entry}`.

The entries follow a fixed cycle. Entry 0 is the Almost-Empty offset bits 7:0. Entry 1 is the Almost-Empty offset bits 15:8. Entry 2 is the Almost-Full offset bits 7:0. Entry 3 is the Almost-Full offset bits 15:8. After entry 3 the cycle goes back to entry 0.

A read output enable forces `rd_data` to zero when it is low. A synchronous active-high reset empties the queue and sets both offsets back to 7.

Top module: `twoclk_fifo`

## Requirements
- R1: During and after reset, the flags read empty=1, almost_empty=1, full=0 and almost_full=0, and rd_data is 0. The offset store reads back as 7, 0, 7, 0 for entries 0 to 3.
- R2: A word is written only on a write-clock edge where wr_en_a and wr_en_b are both 1 and cfg_load is 0. A single asserted enable writes nothing.
- R3: A write attempted while full=1 is dropped. It neither replaces nor adds a word.
- R4: A word is read only when rd_en_a and rd_en_b are both 1 and cfg_load is 0. A read attempted while empty=1 is dropped, and rd_data keeps its previous value.
- R5: Words come out in the order they were written. The read data appears on rd_data after the read-clock edge that accepts the read. The first word written into an empty buffer is readable as soon as empty falls.
- R6: Once both sides have settled, with N words stored out of DEPTH, empty equals (N==0) and full equals (N==DEPTH).
- R7: Once settled, almost_empty equals (N <= AE). AE is entry1*256 + entry0.
- R8: Once settled, almost_full equals (N + AF >= DEPTH). AF is entry3*256 + entry2.
- R9: While cfg_load=1, each write with both enables high stores wr_data[7:0] into the next offset entry, in the order 0, 1, 2, 3 and then back to 0. The queue is not changed.
- R10: While cfg_load=1, each read with both enables high puts {1'b0, entry} on rd_data for the next entry, in the same order. The queue is not changed.
- R11: On a clock edge where cfg_load is 1 after being 0 on the previous edge of that clock, the write-side and read-side entry counters restart at entry 0.
- R12: While oe=0, rd_data is all zeros. Raising oe again shows the held read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| wr_data | input | 9 | Write word, or offset byte in bits 7:0 while loading |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| oe | input | 1 | Read output enable |
| cfg_load | input | 1 | Routes the data ports to the offset store |
| rd_data | output | 9 | Read word or offset readback |
| empty | output | 1 | No word available (read side) |
| almost_empty | output | 1 | Fill at or below the Almost-Empty offset (read side) |
| full | output | 1 | DEPTH words stored (write side) |
| almost_full | output | 1 | Fill within the Almost-Full offset of DEPTH (write side) |

## Verification
The bench goes after the edges of each flag.

- It fills to exactly one word below and at each threshold, at both the default and the programmed offsets. A flag computed with an off-by-one compare, or from the wrong offset half, shows up there as a wrong level.
- A write that lands while the buffer is full must not surface later during the drain. A design that wrapped its pointer would deliver that word, or lose the oldest one.
- The load cycle is exercised three ways: across its wrap, after a restart in the middle of the cycle, and after reset. A counter that did not restart on cfg_load rising, or a readback that advanced the queue pointer, would return entries out of order or consume queued words.

// File: rtl/tcf_pkg.sv
`timescale 1ns/1ps
package tcf_pkg;
  localparam int WORD_W  = 9;
  localparam int PART_W  = 8;
  localparam int N_PARTS = 4;
  localparam int OFS_W   = 2 * PART_W;
  localparam int PIDX_W  = $clog2(N_PARTS);
  localparam int GRAY_W  = 16;

  // entry 0/1: almost-empty offset low/high, entry 2/3: almost-full low/high
  localparam logic [N_PARTS-1:0][PART_W-1:0] OFS_DEFAULT = {8'd0, 8'd7, 8'd0, 8'd7};

  function automatic logic [GRAY_W-1:0] bin2gray(input logic [GRAY_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GRAY_W-1:0] gray2bin(input logic [GRAY_W-1:0] g);
    logic [GRAY_W-1:0] b;
    b[GRAY_W-1] = g[GRAY_W-1];
    for (int i = GRAY_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/tcf_sync.sv
`timescale 1ns/1ps
module tcf_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk) begin
      if (rst) stg <= '0;
      else     stg <= d;
    end
  end else begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) stg <= '0;
      else     stg <= {stg[STAGES-2:0], d};
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tcf_ram.sv
`timescale 1ns/1ps
module tcf_ram #(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 1 << AW;
  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tcf_wr_side.sv
`timescale 1ns/1ps
module tcf_wr_side
  import tcf_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             en_a,
  input  logic                             en_b,
  input  logic                             ld,
  input  logic [WORD_W-1:0]                din,
  input  logic [AW:0]                      rgray_sync,
  output logic                             ram_we,
  output logic [AW-1:0]                    ram_waddr,
  output logic [AW:0]                      wgray,
  output logic [AW:0]                      wbin,
  output logic                             full,
  output logic                             almost_full,
  output logic [N_PARTS-1:0][PART_W-1:0]   parts
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic              both, push, load_wr;
  logic [PW-1:0]     wbin_nx, rbin_s, fill_nx;
  logic [OFS_W-1:0]  af_ofs;
  logic [OFS_W:0]    af_sum;
  logic              ld_q;
  logic [PIDX_W-1:0] pidx_q, pidx_eff;

  assign both    = en_a & en_b;
  assign push    = both & ~ld & ~full;
  assign load_wr = both & ld;

  assign wbin_nx = wbin + PW'(push);
  assign rbin_s  = PW'(gray2bin(GRAY_W'(rgray_sync)));
  assign fill_nx = wbin_nx - rbin_s;
  assign af_ofs  = {parts[3], parts[2]};
  assign af_sum  = (OFS_W+1)'(fill_nx) + (OFS_W+1)'(af_ofs);

  assign pidx_eff  = (ld && !ld_q) ? '0 : pidx_q;
  assign ram_we    = push;
  assign ram_waddr = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin        <= '0;
      wgray       <= '0;
      full        <= 1'b0;
      almost_full <= 1'b0;
      ld_q        <= 1'b0;
      pidx_q      <= '0;
      parts       <= OFS_DEFAULT;
    end else begin
      wbin        <= wbin_nx;
      wgray       <= PW'(bin2gray(GRAY_W'(wbin_nx)));
      full        <= (fill_nx == PW'(DEPTH));
      almost_full <= (af_sum >= (OFS_W+1)'(DEPTH));
      ld_q        <= ld;
      if (load_wr) begin
        parts[pidx_eff] <= din[PART_W-1:0];
        pidx_q          <= pidx_eff + 1'b1;
      end else begin
        pidx_q <= pidx_eff;
      end
    end
  end
endmodule

// File: rtl/tcf_rd_side.sv
`timescale 1ns/1ps
module tcf_rd_side
  import tcf_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             en_a,
  input  logic                             en_b,
  input  logic                             ld,
  input  logic                             oe,
  input  logic [AW:0]                      wgray_sync,
  input  logic [N_PARTS-1:0][PART_W-1:0]   parts,
  input  logic [WORD_W-1:0]                ram_rdata,
  output logic                             ram_re,
  output logic [AW-1:0]                    ram_raddr,
  output logic [AW:0]                      rgray,
  output logic [AW:0]                      rbin,
  output logic                             empty,
  output logic                             almost_empty,
  output logic [WORD_W-1:0]                rd_data
);
  localparam int PW = AW + 1;

  logic              both, pop, rb_rd;
  logic [PW-1:0]     rbin_nx, wbin_s, fill_nx;
  logic [OFS_W-1:0]  ae_ofs;
  logic              ld_q, use_rb;
  logic [PIDX_W-1:0] pidx_q, pidx_eff;
  logic [WORD_W-1:0] rb_q;

  assign both    = en_a & en_b;
  assign pop     = both & ~ld & ~empty;
  assign rb_rd   = both & ld;

  assign rbin_nx = rbin + PW'(pop);
  assign wbin_s  = PW'(gray2bin(GRAY_W'(wgray_sync)));
  assign fill_nx = wbin_s - rbin_nx;
  assign ae_ofs  = {parts[1], parts[0]};

  assign pidx_eff  = (ld && !ld_q) ? '0 : pidx_q;
  assign ram_re    = pop;
  assign ram_raddr = rbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin         <= '0;
      rgray        <= '0;
      empty        <= 1'b1;
      almost_empty <= 1'b1;
      ld_q         <= 1'b0;
      pidx_q       <= '0;
      use_rb       <= 1'b1;
      rb_q         <= '0;
    end else begin
      rbin         <= rbin_nx;
      rgray        <= PW'(bin2gray(GRAY_W'(rbin_nx)));
      empty        <= (fill_nx == '0);
      almost_empty <= (OFS_W'(fill_nx) <= ae_ofs);
      ld_q         <= ld;
      if (rb_rd) begin
        rb_q   <= WORD_W'(parts[pidx_eff]);
        pidx_q <= pidx_eff + 1'b1;
        use_rb <= 1'b1;
      end else begin
        pidx_q <= pidx_eff;
        if (pop) use_rb <= 1'b0;
      end
    end
  end

  assign rd_data = oe ? (use_rb ? rb_q : ram_rdata) : '0;
endmodule

// File: rtl/twoclk_fifo.sv
`timescale 1ns/1ps
module twoclk_fifo
  import tcf_pkg::*;
#(
  parameter int DEPTH       = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst,
  input  logic              wr_en_a,
  input  logic              wr_en_b,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en_a,
  input  logic              rd_en_b,
  input  logic              oe,
  input  logic              cfg_load,
  output logic [WORD_W-1:0] rd_data,
  output logic              empty,
  output logic              almost_empty,
  output logic              full,
  output logic              almost_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0]     wgray, rgray, wgray_rs, rgray_ws, wbin, rbin;
  logic              ram_we, ram_re;
  logic [AW-1:0]     ram_waddr, ram_raddr;
  logic [WORD_W-1:0] ram_rdata;
  logic [N_PARTS-1:0][PART_W-1:0] parts;

  tcf_wr_side #(.AW(AW)) u_wr (
    .clk(wclk), .rst(rst), .en_a(wr_en_a), .en_b(wr_en_b), .ld(cfg_load),
    .din(wr_data), .rgray_sync(rgray_ws), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .wgray(wgray), .wbin(wbin), .full(full), .almost_full(almost_full), .parts(parts)
  );

  tcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk(rclk), .rst(rst), .d(wgray), .q(wgray_rs)
  );

  tcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk(wclk), .rst(rst), .d(rgray), .q(rgray_ws)
  );

  tcf_ram #(.AW(AW), .DW(WORD_W)) u_ram (
    .wclk(wclk), .we(ram_we), .waddr(ram_waddr), .wdata(wr_data),
    .rclk(rclk), .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata)
  );

  tcf_rd_side #(.AW(AW)) u_rd (
    .clk(rclk), .rst(rst), .en_a(rd_en_a), .en_b(rd_en_b), .ld(cfg_load), .oe(oe),
    .wgray_sync(wgray_rs), .parts(parts), .ram_rdata(ram_rdata), .ram_re(ram_re),
    .ram_raddr(ram_raddr), .rgray(rgray), .rbin(rbin), .empty(empty),
    .almost_empty(almost_empty), .rd_data(rd_data)
  );
endmodule

// File: rtl/tcf_checker.sv
`timescale 1ns/1ps
module tcf_checker
  import tcf_pkg::*;
#(
  parameter int AW = 10
) (
  input logic        wclk,
  input logic        rclk,
  input logic        rst,
  input logic        wr_en_a,
  input logic        wr_en_b,
  input logic        rd_en_a,
  input logic        rd_en_b,
  input logic        cfg_load,
  input logic        empty,
  input logic        almost_empty,
  input logic        full,
  input logic        almost_full,
  input logic [AW:0] wbin,
  input logic [AW:0] rbin,
  input logic [AW:0] rgray_ws
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] rbin_w;
  assign rbin_w = PW'(gray2bin(GRAY_W'(rgray_ws)));

  p_reset_flags_r1: assert property (@(posedge rclk) disable iff (rst)
    $past(rst) |-> (empty && almost_empty));

  p_wr_qual_r2: assert property (@(posedge wclk) disable iff (rst)
    !(wr_en_a && wr_en_b) |=> $stable(wbin));

  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (rst)
    (full && wr_en_a && wr_en_b) |=> $stable(wbin));

  p_no_underflow_r4: assert property (@(posedge rclk) disable iff (rst)
    (empty && rd_en_a && rd_en_b) |=> $stable(rbin));

  p_fill_bound_r6: assert property (@(posedge wclk) disable iff (rst)
    PW'(wbin - rbin_w) <= PW'(DEPTH));

  p_empty_ae_r7: assert property (@(posedge rclk) disable iff (rst)
    empty |-> almost_empty);

  p_full_af_r8: assert property (@(posedge wclk) disable iff (rst)
    full |-> almost_full);

  p_load_wr_hold_r9: assert property (@(posedge wclk) disable iff (rst)
    cfg_load |=> $stable(wbin));

  p_load_rd_hold_r10: assert property (@(posedge rclk) disable iff (rst)
    cfg_load |=> $stable(rbin));
endmodule

bind twoclk_fifo tcf_checker #(.AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en_a(wr_en_a), .wr_en_b(wr_en_b),
  .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .cfg_load(cfg_load), .empty(empty),
  .almost_empty(almost_empty), .full(full), .almost_full(almost_full),
  .wbin(wbin), .rbin(rbin), .rgray_ws(rgray_ws)
);

// File: tb/test_twoclk_fifo.sv
`timescale 1ns/1ps
module test_twoclk_fifo;
  localparam int D = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wa = 0, wb = 0, ra = 0, rb = 0, ld = 0, oe = 1;
  logic [8:0] din = '0;
  logic [8:0] rd_data;
  logic empty, almost_empty, full, almost_full;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int         q[$];
  logic [7:0] ofs[4];
  int         mw = 0, mr = 0;
  bit         mprev = 0;
  logic [8:0] last_rd = '0;

  always #10 clk = ~clk;

  twoclk_fifo #(.DEPTH(D)) i_twoclk_fifo (
    .wclk(clk), .rclk(clk), .rst(rst), .wr_en_a(wa), .wr_en_b(wb), .wr_data(din),
    .rd_en_a(ra), .rd_en_b(rb), .oe(oe), .cfg_load(ld), .rd_data(rd_data),
    .empty(empty), .almost_empty(almost_empty), .full(full), .almost_full(almost_full)
  );

  function automatic int ae_val(); return int'(ofs[1]) * 256 + int'(ofs[0]); endfunction
  function automatic int af_val(); return int'(ofs[3]) * 256 + int'(ofs[2]); endfunction
  function automatic bit x_empty(int n); return n == 0; endfunction
  function automatic bit x_full(int n); return n == D; endfunction
  function automatic bit x_ae(int n); return n <= ae_val(); endfunction
  function automatic bit x_af(int n); return (n + af_val()) >= D; endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, act at posedge, observe at next negedge
  task automatic step(bit a, bit b, bit c, bit d, bit l, logic [8:0] dat, string req);
    bit         f0 = full;
    bit         e0 = empty;
    int         wi, ri, exp;
    logic [7:0] ofs_old[4];
    wa = a; wb = b; ra = c; rb = d; ld = l; din = dat;
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 4; k++) ofs_old[k] = ofs[k];
    wi = (l && !mprev) ? 0 : mw;
    ri = (l && !mprev) ? 0 : mr;
    if (a && b && l) begin ofs[wi] = dat[7:0]; mw = (wi + 1) % 4; end else mw = wi;
    if (a && b && !l && !f0) q.push_back(int'(dat));
    if (c && d && l) begin
      last_rd = {1'b0, ofs_old[ri]};
      mr = (ri + 1) % 4;
      exp = oe ? int'(last_rd) : 0;
      chk(rd_data == 9'(exp), {req, " readback"}, int'(rd_data), exp);
    end else begin
      mr = ri;
      if (c && d && !e0) begin
        last_rd = 9'(q.pop_front());
        exp = oe ? int'(last_rd) : 0;
        chk(rd_data == 9'(exp), {req, " read data"}, int'(rd_data), exp);
      end
    end
    mprev = l;
    wa = 0; wb = 0; ra = 0; rb = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, '0, "idle");
  endtask

  task automatic flags(string req);
    int n;
    idle(5);
    n = q.size();
    chk(empty == x_empty(n), {req, " empty"}, int'(empty), int'(x_empty(n)));
    chk(full == x_full(n), {req, " full"}, int'(full), int'(x_full(n)));
    chk(almost_empty == x_ae(n), {req, " almost_empty"}, int'(almost_empty), int'(x_ae(n)));
    chk(almost_full == x_af(n), {req, " almost_full"}, int'(almost_full), int'(x_af(n)));
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    chk(empty == 1 && almost_empty == 1 && full == 0 && almost_full == 0, "R1 flags in reset",
        int'({empty, almost_empty, full, almost_full}), 4'b1100);
    rst = 0;
    @(negedge clk);
    q.delete();
    ofs[0] = 8'd7; ofs[1] = 8'd0; ofs[2] = 8'd7; ofs[3] = 8'd0;
    mw = 0; mr = 0; mprev = 0; last_rd = '0;
  endtask

  task automatic write_n(int n, int base);
    for (int i = 0; i < n; i++) step(1, 1, 0, 0, 0, 9'(base + i), "R5 fill");
  endtask

  task automatic drain(string req);
    while (q.size() > 0) step(0, 0, 1, 1, 0, '0, req);
  endtask

  initial begin
    void'($urandom(32'd4321));
    @(negedge clk);
    do_reset();
    chk(rd_data == 9'd0, "R1 rd_data after reset", int'(rd_data), 0);
    flags("R1");

    // R2: single enables write nothing
    step(1, 0, 0, 0, 0, 9'h0AA, "R2");
    step(0, 1, 0, 0, 0, 9'h0BB, "R2");
    flags("R2 single write enable");
    step(1, 1, 0, 0, 0, 9'h155, "R5");
    flags("R5 zero fall-through");
    // R4: single read enables consume nothing
    step(0, 0, 1, 0, 0, '0, "R4");
    step(0, 0, 0, 1, 0, '0, "R4");
    flags("R4 single read enable");
    step(0, 0, 1, 1, 0, '0, "R5");
    flags("R6 empty again");
    step(0, 0, 1, 1, 0, '0, "R4");
    chk(rd_data == 9'h155, "R4 read while empty holds data", int'(rd_data), 9'h155);

    // default thresholds and full
    write_n(7, 16);   flags("R7 default at 7");
    write_n(1, 23);   flags("R7 default at 8");
    write_n(D - 16, 24); flags("R8 default below");
    write_n(1, 300);  flags("R8 default at limit");
    write_n(7, 301);  flags("R6 full");
    step(1, 1, 0, 0, 0, 9'h1AA, "R3");
    flags("R3 write while full");
    drain("R3 R5 drain");
    flags("R6 empty after drain");

    // offset loading with queued words left untouched
    write_n(3, 100);
    step(1, 1, 0, 0, 1, 9'h021, "R9");
    step(1, 1, 0, 0, 1, 9'h001, "R9");
    step(1, 1, 0, 0, 1, 9'h043, "R9");
    step(1, 1, 0, 0, 1, 9'h000, "R9");
    for (int i = 0; i < 5; i++) step(0, 0, 1, 1, 1, '0, "R10 R9");
    step(0, 0, 0, 0, 0, '0, "R11");
    step(0, 0, 1, 1, 1, '0, "R11 read restart");
    step(0, 0, 0, 0, 0, '0, "R11");
    flags("R10 queue untouched");
    drain("R10 drain");
    // write-side restart mid-cycle
    step(1, 1, 0, 0, 1, 9'h055, "R11");
    step(1, 1, 0, 0, 1, 9'h066, "R11");
    step(0, 0, 0, 0, 0, '0, "R11");
    step(1, 1, 0, 0, 1, 9'd20, "R11");
    step(1, 1, 0, 0, 1, 9'd0, "R11");
    step(1, 1, 0, 0, 1, 9'd48, "R11");
    step(1, 1, 0, 0, 1, 9'd0, "R11");
    step(0, 0, 0, 0, 0, '0, "R11");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 1, '0, "R11 R10");
    step(0, 0, 0, 0, 0, '0, "R7");
    write_n(20, 0);     flags("R7 programmed at 20");
    write_n(1, 20);     flags("R7 programmed at 21");
    write_n(186, 21);   flags("R8 programmed at 207");
    write_n(1, 207);    flags("R8 programmed at 208");
    drain("R5 drain");

    // output enable
    write_n(1, 9'h0C3);
    idle(4);
    oe = 0;
    step(0, 0, 1, 1, 0, '0, "R12 oe low");
    chk(rd_data == 9'd0, "R12 oe low forces zero", int'(rd_data), 0);
    oe = 1;
    #1;
    chk(rd_data == 9'h0C3, "R12 oe high shows word", int'(rd_data), 9'h0C3);

    // reset restores default offsets
    do_reset();
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 1, '0, "R1 default offsets");
    step(0, 0, 0, 0, 0, '0, "R1");

    // constrained random, write-heavy then read-heavy
    for (int ph = 0; ph < 4; ph++) begin
      int pw = (ph % 2 == 0) ? 8 : 4;
      int pr = (ph % 2 == 0) ? 4 : 8;
      for (int i = 0; i < 1200; i++) begin
        bit a = ($urandom % 10) < pw;
        bit b = ($urandom % 10) < 9;
        bit c = ($urandom % 10) < pr;
        bit d = ($urandom % 10) < 9;
        step(a, b, c, d, 0, 9'($urandom), "R5 random");
        if (i % 150 == 149) flags("R6 R7 R8 random");
      end
    end
    drain("R5 final drain");
    flags("R6 final");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule